// File: doc/BRIEF.md
# Multi-Stage Hit Timestamp Decoder

This block converts the raw state captured when a hit arrives into a binary timestamp. The captured state has three parts, one for each measurement stage:

- two samples of a fast coarse counter, taken half a coarse period apart;
- a 32-entry snapshot of a delay line whose total delay is one coarse period, with each tap worth roughly 12 ps;
- three interpolation bits per tap, which split each tap interval into four sub-bins of roughly 3 ps.

The decoder works in three steps. It cleans the delay-line snapshot and locates its edge. It picks the coarse sample that was stable at that edge phase. It then counts the interpolation bits of the selected tap.

The decoder is a three-stage pipeline and accepts a new hit on every clock cycle. A resolution selector travels through the pipeline with each hit and chooses between three outputs: the full fine code, tap resolution only, or the coarse count only. A snapshot in which no edge can be found is reported with an error flag rather than a guessed code.

Top module: `tdc_ts_decoder`

## Requirements
- R1: While `rst_n` is low, `ts_vld`, `ts_err` and `ts` are all zero. After release they stay zero until a hit has passed through the pipeline.
- R2: A hit presented with `hit_vld` high at a clock edge appears on the outputs with `ts_vld` high three clock edges later. Hits on consecutive cycles give outputs on consecutive cycles.
- R3: The tap bit of tap t is `hit_bits[4*t]`. After bubble correction, the tap code is the lowest index p whose corrected bit is 1 while the bit at index (p+1) mod 32 is 0. The transition from tap 31 to tap 0 counts as a transition.
- R4: Before the edge search, each tap bit is replaced by the majority of itself and its two circular neighbours. A single flipped bit away from the edge therefore does not change the tap code.
- R5: The sub-bin code is the number of ones among `hit_bits[4*p+3 : 4*p+1]` of the selected tap p, in the range 0 to 3. The interpolation bits of other taps have no effect.
- R6: When the most significant bit of the tap code is 1, the coarse field is taken from `cnt_a`. When it is 0, the coarse field is taken from `cnt_b`.
- R7: With `res_sel` = 0, `ts` = {coarse, tap[4:0], sub[1:0]}.
- R8: With `res_sel` = 1, `ts` has the same layout as in R7, but its two lowest bits are zero.
- R9: With `res_sel` = 2 or 3, the seven lowest bits of `ts` are zero and the coarse field is kept.
- R10: If the corrected snapshot has no 1-to-0 transition (all ones or all zeros), then `ts_err` = 1 and `ts` = 0.
- R11: A cycle with `hit_vld` low produces a cycle with `ts_vld` low three edges later. In that cycle `ts` and `ts_err` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hit_vld | input | 1 | Hit strobe; the captured state is valid in this cycle |
| hit_bits | input | 128 | Per tap t: bit 4t is the tap bit, bits 4t+1..4t+3 are the interpolation bits |
| cnt_a | input | CNT_W (10) | Coarse counter sample used for taps 16 to 31 |
| cnt_b | input | CNT_W (10) | Coarse counter sample taken half a period apart, used for taps 0 to 15 |
| res_sel | input | 2 | 0 full, 1 tap resolution, 2 or 3 coarse only |
| ts_vld | output | 1 | Timestamp valid |
| ts | output | CNT_W+7 (17) | Timestamp {coarse, tap, sub}, truncated by resolution |
| ts_err | output | 1 | The snapshot had no usable edge |

## Verification
A wrong edge search or a broken bubble vote shows up as a tap field that is off by the width of the defect. A wrong counter choice shows up as the other sample in the coarse field. Both appear in the same cycle as `ts_vld`, three edges after the hit. An error in how the valid flag or the resolution mode moves through the pipeline makes results land one cycle early or late, or attaches them to their neighbours in a back-to-back stream. A held register that loads when no hit is present makes `ts` change while `ts_vld` is low.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
  typedef enum logic [1:0] {
    RES_FINE   = 2'd0,
    RES_TAP    = 2'd1,
    RES_COARSE = 2'd2,
    RES_CRS_B  = 2'd3
  } res_mode_t;
endpackage

// File: rtl/tdc_therm_enc.sv
`timescale 1ns/1ps
// Circular thermometer edge finder with three-bit majority bubble vote.
module tdc_therm_enc #(
  parameter int N_TAPS = 32,
  parameter int TAP_W  = $clog2(N_TAPS)
) (
  input  logic [N_TAPS-1:0] therm,
  output logic [TAP_W-1:0]  code,
  output logic              found
);
  logic [N_TAPS-1:0] voted;
  logic [N_TAPS-1:0] edge_v;

  for (genvar i = 0; i < N_TAPS; i++) begin : g_vote
    localparam int PRV = (i + N_TAPS - 1) % N_TAPS;
    localparam int NXT = (i + 1) % N_TAPS;
    assign voted[i]  = (therm[PRV] & therm[i]) | (therm[PRV] & therm[NXT]) |
                       (therm[i] & therm[NXT]);
    assign edge_v[i] = voted[i] & ~voted[NXT];
  end

  // lowest index wins
  always_comb begin
    code = '0;
    for (int i = N_TAPS - 1; i >= 0; i--) begin
      if (edge_v[i]) code = TAP_W'(i);
    end
  end

  assign found = |edge_v;
endmodule

// File: rtl/tdc_interp_sel.sv
`timescale 1ns/1ps
// Picks the interpolation bits that belong to the selected tap.
module tdc_interp_sel #(
  parameter int N_TAPS = 32,
  parameter int N_SUB  = 4,
  parameter int TAP_W  = $clog2(N_TAPS),
  parameter int RAW_W  = N_TAPS * N_SUB
) (
  input  logic [RAW_W-1:0] raw,
  input  logic [TAP_W-1:0] tap,
  output logic [N_SUB-2:0] grp
);
  always_comb begin
    grp = '0;
    for (int t = 0; t < N_TAPS; t++) begin
      if (tap == TAP_W'(t)) grp = raw[t*N_SUB+1 +: N_SUB-1];
    end
  end
endmodule

// File: rtl/tdc_ts_format.sv
`timescale 1ns/1ps
// Sub-bin count, field join and resolution truncation.
module tdc_ts_format
  import tdc_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TAP_W = 5,
  parameter int N_SUB = 4,
  parameter int SUB_W = $clog2(N_SUB),
  parameter int TS_W  = CNT_W + TAP_W + SUB_W
) (
  input  logic [CNT_W-1:0] coarse,
  input  logic [TAP_W-1:0] tap,
  input  logic [N_SUB-2:0] grp,
  input  res_mode_t        mode,
  input  logic             err,
  output logic [TS_W-1:0]  ts
);
  localparam int FINE_W = TAP_W + SUB_W;

  logic [SUB_W-1:0] sub;
  logic [TS_W-1:0]  full;

  always_comb begin
    sub = '0;
    for (int i = 0; i < N_SUB - 1; i++) sub = sub + SUB_W'(grp[i]);
  end

  assign full = {coarse, tap, sub};

  always_comb begin
    if (err) begin
      ts = '0;
    end else begin
      case (mode)
        RES_FINE: ts = full;
        RES_TAP:  ts = {full[TS_W-1:SUB_W], {SUB_W{1'b0}}};
        default:  ts = {coarse, {FINE_W{1'b0}}};
      endcase
    end
  end
endmodule

// File: rtl/tdc_ts_decoder.sv
`timescale 1ns/1ps
module tdc_ts_decoder
  import tdc_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int N_TAPS = 32,
  parameter int N_SUB  = 4,
  localparam int TAP_W = $clog2(N_TAPS),
  localparam int SUB_W = $clog2(N_SUB),
  localparam int RAW_W = N_TAPS * N_SUB,
  localparam int TS_W  = CNT_W + TAP_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_vld,
  input  logic [RAW_W-1:0] hit_bits,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  input  logic [1:0]       res_sel,
  output logic             ts_vld,
  output logic [TS_W-1:0]  ts,
  output logic             ts_err
);
  // reset release synchronizer
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // stage 1: capture
  logic             s1_vld;
  logic [RAW_W-1:0] s1_raw;
  logic [CNT_W-1:0] s1_cnt_a, s1_cnt_b;
  res_mode_t        s1_mode;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) s1_vld <= 1'b0;
    else            s1_vld <= hit_vld;
  end

  always_ff @(posedge clk) begin
    if (hit_vld) begin
      s1_raw   <= hit_bits;
      s1_cnt_a <= cnt_a;
      s1_cnt_b <= cnt_b;
      s1_mode  <= res_mode_t'(res_sel);
    end
  end

  // stage 2 next state: edge search, interpolation pick, counter choice
  logic [N_TAPS-1:0] s1_therm;
  logic [TAP_W-1:0]  s2_tap_d;
  logic              s2_found_d;
  logic [N_SUB-2:0]  s2_grp_d;
  logic [CNT_W-1:0]  s2_coarse_d;

  for (genvar t = 0; t < N_TAPS; t++) begin : g_therm
    assign s1_therm[t] = s1_raw[t*N_SUB];
  end

  tdc_therm_enc #(
    .N_TAPS (N_TAPS),
    .TAP_W  (TAP_W)
  ) u_enc (
    .therm (s1_therm),
    .code  (s2_tap_d),
    .found (s2_found_d)
  );

  tdc_interp_sel #(
    .N_TAPS (N_TAPS),
    .N_SUB  (N_SUB),
    .TAP_W  (TAP_W),
    .RAW_W  (RAW_W)
  ) u_isel (
    .raw (s1_raw),
    .tap (s2_tap_d),
    .grp (s2_grp_d)
  );

  always_comb begin
    s2_coarse_d = s2_tap_d[TAP_W-1] ? s1_cnt_a : s1_cnt_b;
  end

  // stage 2 registers
  logic             s2_vld;
  logic [TAP_W-1:0] s2_tap;
  logic             s2_err;
  logic [N_SUB-2:0] s2_grp;
  logic [CNT_W-1:0] s2_coarse;
  res_mode_t        s2_mode;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) s2_vld <= 1'b0;
    else            s2_vld <= s1_vld;
  end

  always_ff @(posedge clk) begin
    if (s1_vld) begin
      s2_tap    <= s2_tap_d;
      s2_err    <= ~s2_found_d;
      s2_grp    <= s2_grp_d;
      s2_coarse <= s2_coarse_d;
      s2_mode   <= s1_mode;
    end
  end

  // stage 3 next state: format
  logic [TS_W-1:0] ts_d;

  tdc_ts_format #(
    .CNT_W (CNT_W),
    .TAP_W (TAP_W),
    .N_SUB (N_SUB),
    .SUB_W (SUB_W),
    .TS_W  (TS_W)
  ) u_fmt (
    .coarse (s2_coarse),
    .tap    (s2_tap),
    .grp    (s2_grp),
    .mode   (s2_mode),
    .err    (s2_err),
    .ts     (ts_d)
  );

  // stage 3 registers (outputs)
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ts_vld <= 1'b0;
      ts     <= '0;
      ts_err <= 1'b0;
    end else begin
      ts_vld <= s2_vld;
      if (s2_vld) begin
        ts     <= ts_d;
        ts_err <= s2_err;
      end
    end
  end
endmodule

// File: rtl/tdc_ts_decoder_chk.sv
`timescale 1ns/1ps
module tdc_ts_decoder_chk #(
  parameter int TS_W   = 17,
  parameter int SUB_W  = 2,
  parameter int FINE_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hit_vld,
  input logic [1:0]      res_sel,
  input logic            ts_vld,
  input logic [TS_W-1:0] ts,
  input logic            ts_err
);
  // cycles since reset release; covers the internal synchronizer and pipeline
  logic [2:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           warm <= 3'd0;
    else if (warm != 3'd7) warm <= warm + 3'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_out_r1: assert (!ts_vld && !ts_err && ts == '0)
        else $error("outputs not cleared in reset");
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'd5) |-> (ts_vld == $past(hit_vld, 3)));

  p_tap_res_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'd5 && ts_vld && $past(res_sel, 3) == 2'd1) |-> (ts[SUB_W-1:0] == '0));

  p_coarse_res_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'd5 && ts_vld && $past(res_sel[1], 3)) |-> (ts[FINE_W-1:0] == '0));

  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ts_err |-> (ts == '0));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 3'd1 && !ts_vld) |-> ($stable(ts) && $stable(ts_err)));
endmodule

bind tdc_ts_decoder tdc_ts_decoder_chk #(
  .TS_W   (TS_W),
  .SUB_W  (SUB_W),
  .FINE_W (TAP_W + SUB_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hit_vld (hit_vld),
  .res_sel (res_sel),
  .ts_vld  (ts_vld),
  .ts      (ts),
  .ts_err  (ts_err)
);

// File: tb/tdc_ts_decoder_bench.sv
`timescale 1ns/1ps
module tdc_ts_decoder_bench;
  localparam int CNT_W = 10;
  localparam int TS_W  = CNT_W + 7;
  localparam int NV    = 14;

  typedef struct packed {
    logic [4:0]       p;
    logic [5:0]       len;
    logic [1:0]       subn;
    logic [CNT_W-1:0] ca;
    logic [CNT_W-1:0] cb;
    logic [1:0]       mode;
    logic [5:0]       bub;   // 63: no bubble
  } vec_t;

  // p, run length, sub ones, cnt_a, cnt_b, mode, bubble tap
  localparam vec_t VEC [NV] = '{
    '{5'd5,  6'd6,  2'd2, 10'd100, 10'd200, 2'd0, 6'd63},  // R3 R5 R6 R7
    '{5'd20, 6'd10, 2'd3, 10'd300, 10'd301, 2'd0, 6'd63},  // R6 cnt_a
    '{5'd1,  6'd5,  2'd1, 10'd7,   10'd9,   2'd0, 6'd63},  // R3 run wraps
    '{5'd31, 6'd4,  2'd2, 10'd1000,10'd3,   2'd0, 6'd63},  // R3 edge 31->0
    '{5'd10, 6'd8,  2'd1, 10'd55,  10'd66,  2'd1, 6'd63},  // R8
    '{5'd25, 6'd12, 2'd3, 10'd511, 10'd5,   2'd2, 6'd63},  // R9
    '{5'd7,  6'd7,  2'd2, 10'd1,   10'd1023,2'd3, 6'd63},  // R9 alt code
    '{5'd15, 6'd10, 2'd1, 10'd40,  10'd41,  2'd0, 6'd10},  // R4 hole in ones
    '{5'd15, 6'd10, 2'd2, 10'd42,  10'd43,  2'd0, 6'd25},  // R4 spike in zeros
    '{5'd3,  6'd0,  2'd1, 10'd77,  10'd78,  2'd0, 6'd63},  // R10 all zeros
    '{5'd3,  6'd32, 2'd1, 10'd79,  10'd80,  2'd0, 6'd63},  // R10 all ones
    '{5'd0,  6'd3,  2'd0, 10'd11,  10'd12,  2'd0, 6'd63},  // R3 tap 0
    '{5'd16, 6'd16, 2'd0, 10'd600, 10'd601, 2'd0, 6'd63},  // R6 boundary a
    '{5'd15, 6'd16, 2'd3, 10'd602, 10'd603, 2'd0, 6'd63}   // R6 boundary b
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            hit_vld;
  logic [127:0]    hit_bits;
  logic [CNT_W-1:0] cnt_a, cnt_b;
  logic [1:0]      res_sel;
  logic            ts_vld;
  logic [TS_W-1:0] ts;
  logic            ts_err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  tdc_ts_decoder u_tdc_ts_decoder (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_vld  (hit_vld),
    .hit_bits (hit_bits),
    .cnt_a    (cnt_a),
    .cnt_b    (cnt_b),
    .res_sel  (res_sel),
    .ts_vld   (ts_vld),
    .ts       (ts),
    .ts_err   (ts_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] build(vec_t v);
    logic [127:0] r;
    r = '0;
    for (int t = 0; t < 32; t++) r[4*t+1 +: 3] = 3'b101;
    r[4*v.p+1 +: 3] = 3'((4'd1 << v.subn) - 4'd1);
    for (int i = 0; i < 32; i++) begin
      if (i < int'(v.len)) r[4*((int'(v.p) - i + 64) % 32)] = 1'b1;
    end
    if (v.bub < 6'd32) r[4*v.bub] = ~r[4*v.bub];
    return r;
  endfunction

  function automatic logic [TS_W-1:0] exp_ts(vec_t v);
    logic [CNT_W-1:0] c;
    logic [TS_W-1:0]  f;
    if (v.len == 6'd0 || v.len == 6'd32) return '0;
    c = v.p[4] ? v.ca : v.cb;
    f = {c, v.p, v.subn};
    case (v.mode)
      2'd0:    return f;
      2'd1:    return {f[TS_W-1:2], 2'b00};
      default: return {c, 7'd0};
    endcase
  endfunction

  function automatic logic exp_err(vec_t v);
    return (v.len == 6'd0 || v.len == 6'd32);
  endfunction

  task automatic drive(vec_t v);
    hit_vld  = 1'b1;
    hit_bits = build(v);
    cnt_a    = v.ca;
    cnt_b    = v.cb;
    res_sel  = v.mode;
  endtask

  task automatic check_vec(int i);
    chk($sformatf("R2 vld vec%0d", i), 32'(ts_vld), 32'd1);
    chk($sformatf("R3-R10 ts vec%0d", i), 32'(ts), 32'(exp_ts(VEC[i])));
    chk($sformatf("R10 err vec%0d", i), 32'(ts_err), 32'(exp_err(VEC[i])));
  endtask

  initial begin
    rst_n    = 1'b0;
    hit_vld  = 1'b0;
    hit_bits = '0;
    cnt_a    = '0;
    cnt_b    = '0;
    res_sel  = 2'd0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared in reset
    chk("R1 vld", 32'(ts_vld), 32'd0);
    chk("R1 ts", 32'(ts), 32'd0);
    chk("R1 err", 32'(ts_err), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 vld idle", 32'(ts_vld), 32'd0);

    // back-to-back stream (R2 throughput)
    for (int n = 0; n < NV + 3; n++) begin
      @(negedge clk);
      if (n >= 3) check_vec(n - 3);
      if (n < NV) drive(VEC[n]);
      else        hit_vld = 1'b0;
    end

    // R11: no hit, inputs churn, outputs hold
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      hit_bits = {4{32'hA5C3_0F96 ^ 32'(k)}};
      cnt_a    = CNT_W'(k * 37);
      cnt_b    = CNT_W'(k * 91);
      res_sel  = 2'(k);
      chk("R11 vld low", 32'(ts_vld), 32'd0);
      chk("R11 ts held", 32'(ts), 32'(exp_ts(VEC[NV-1])));
      chk("R11 err held", 32'(ts_err), 32'd0);
    end

    // R2: single-hit latency of three edges
    @(negedge clk);
    drive(VEC[1]);
    @(negedge clk);
    hit_vld = 1'b0;
    chk("R2 not yet +1", 32'(ts_vld), 32'd0);
    @(negedge clk);
    chk("R2 not yet +2", 32'(ts_vld), 32'd0);
    @(negedge clk);
    chk("R2 vld +3", 32'(ts_vld), 32'd1);
    chk("R6 ts +3", 32'(ts), 32'(exp_ts(VEC[1])));
    @(negedge clk);
    chk("R11 vld after", 32'(ts_vld), 32'd0);

    // R10 followed by a good hit: error clears
    drive(VEC[9]);
    @(negedge clk);
    drive(VEC[0]);
    @(negedge clk);
    hit_vld = 1'b0;
    @(negedge clk);
    chk("R10 err set", 32'(ts_err), 32'd1);
    chk("R10 ts zero", 32'(ts), 32'd0);
    @(negedge clk);
    chk("R10 err clear", 32'(ts_err), 32'd0);
    chk("R7 ts next", 32'(ts), 32'(exp_ts(VEC[0])));

    // R1: reset mid-run clears the outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rerst vld", 32'(ts_vld), 32'd0);
    chk("R1 rerst ts", 32'(ts), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule